// File: doc/BRIEF.md
# UART Transmit Frame Generator

This block turns requests into frames on a serial transmit line. It does not divide the clock. An external baud source pulses `tick_i` once per oversampling sample. Each bit lasts 16 samples in x16 mode and 8 samples in x8 mode. Three kinds of frame can be requested:
- a data frame: one low start bit, eight data bits sent least significant bit first, then a high stop period;
- a fill (idle) frame: the line stays high for exactly the length of a data frame;
- a break frame: the line is held low for nine bit times, then the stop period follows.

The stop period can be half a bit, one bit, one and a half bits or two bits long. Half-bit lengths are counted in samples.

A request is a one-cycle strobe. It is taken only while the block is not busy. At the moment it is taken, the byte, the stop-length code and the oversampling mode are all captured, so later changes to those inputs do not disturb the frame in flight. Strobes that arrive during a frame are dropped. When the block is quiet the line rests high.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `tx_o` is high.
- R2: A data frame is 1 low start bit, then `data_i[0]` through `data_i[7]`, then a high stop period. Each bit lasts 16 ticks when `os8_i`=0 and 8 ticks when `os8_i`=1.
- R3: The stop-length code `stop_sel_i` sets the stop period. 2'b00 gives 1 bit, 2'b01 gives 0.5 bit, 2'b10 gives 2 bits and 2'b11 gives 1.5 bits. In x16 mode that is 16, 8, 32 or 24 ticks; in x8 mode it is 8, 4, 16 or 12 ticks.
- R4: A fill frame (`idle_req_i`) keeps `tx_o` high for 9 bit times plus the stop period, the same length as a data frame with the same settings.
- R5: A break frame (`brk_req_i`) drives `tx_o` low for 9 bit times, then high for the configured stop period.
- R6: `busy_o` rises, and the first level of the frame appears, on the cycle after a request is accepted. `busy_o` falls on the cycle after the clock edge that consumes the last stop tick.
- R7: Requests that arrive while busy are ignored and not queued. Changes to `data_i`, `stop_sel_i` and `os8_i` during a frame do not affect it.
- R8: When more than one strobe is high in the accepting cycle, break wins over fill, and fill wins over data.
- R9: The frame advances only on cycles with `tick_i` high; any spacing of ticks gives the same sequence of levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One oversampling sample per high cycle |
| data_i | input | 8 | Byte for a data frame |
| send_i | input | 1 | Data-frame request strobe |
| idle_req_i | input | 1 | Fill-frame request strobe |
| brk_req_i | input | 1 | Break-frame request strobe |
| stop_sel_i | input | 2 | Stop-length code (see R3) |
| os8_i | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| tx_o | output | 1 | Serial transmit line |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
A request captured at one clock edge shows on `busy_o` and `tx_o` from the next cycle. The bench therefore checks `busy_o` at the falling edge that follows the accepting edge. After that, every cycle with `tick_i` high consumes one sample of the frame, and the level expected for that sample is compared at the falling edge of that same cycle. `busy_o` is due low exactly one cycle after the last expected sample has been consumed. The monitor checks that cycle, and it also flags a tick seen while busy with nothing left to expect, or a drop of `busy_o` while samples are still outstanding.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BODY = 2'd1,
        PH_STOP = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        FR_DATA  = 2'd0,
        FR_FILL  = 2'd1,
        FR_BREAK = 2'd2
    } kind_e;

endpackage

// File: rtl/uart_txf_timing.sv
module uart_txf_timing #(
    parameter int OS_HI = 16,
    parameter int OS_LO = 8,
    parameter int CNT_W = 6
) (
    input  logic             os8_i,
    input  logic [1:0]       stop_sel_i,
    output logic [CNT_W-1:0] bit_ticks_o,
    output logic [CNT_W-1:0] stop_ticks_o
);

    logic [CNT_W-1:0] bit_t;
    logic [CNT_W-1:0] half_t;

    assign bit_t  = os8_i ? CNT_W'(OS_LO) : CNT_W'(OS_HI);
    assign half_t = bit_t >> 1;

    always_comb begin
        unique case (stop_sel_i)
            2'b00:   stop_ticks_o = bit_t;
            2'b01:   stop_ticks_o = half_t;
            2'b10:   stop_ticks_o = bit_t << 1;
            default: stop_ticks_o = bit_t + half_t;
        endcase
    end

    assign bit_ticks_o = bit_t;

endmodule

// File: rtl/uart_txf_level.sv
module uart_txf_level
    import uart_txf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLOT_W = 4
) (
    input  phase_e            phase_i,
    input  kind_e             kind_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              level_o
);

    logic data_bit;

    // slot 0 is the start bit, slot k carries data bit k-1
    always_comb begin
        data_bit = 1'b0;
        for (int k = 0; k < DATA_W; k++) begin
            if (slot_i == SLOT_W'(k + 1)) data_bit = data_i[k];
        end
    end

    always_comb begin
        level_o = 1'b1;
        if (phase_i == PH_BODY) begin
            unique case (kind_i)
                FR_DATA:  level_o = (slot_i == '0) ? 1'b0 : data_bit;
                FR_FILL:  level_o = 1'b1;
                default:  level_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_txf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OS_HI  = 16,
    parameter int OS_LO  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              send_i,
    input  logic              idle_req_i,
    input  logic              brk_req_i,
    input  logic [1:0]        stop_sel_i,
    input  logic              os8_i,
    output logic              tx_o,
    output logic              busy_o
);

    localparam int CNT_W  = $clog2(2 * OS_HI + 1);
    localparam int SLOT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        phase_e            phase;
        kind_e             kind;
        logic [DATA_W-1:0] data;
        logic [SLOT_W-1:0] slot;
        logic [CNT_W-1:0]  tcnt;
        logic [1:0]        stop_sel;
        logic              os8;
    } state_t;

    state_t s_d, s_q;

    logic             any_req;
    logic             accept;
    kind_e            req_kind;
    logic [CNT_W-1:0] bit_ticks;
    logic [CNT_W-1:0] stop_ticks;
    logic             level;

    uart_txf_timing #(
        .OS_HI (OS_HI),
        .OS_LO (OS_LO),
        .CNT_W (CNT_W)
    ) u_timing (
        .os8_i        (s_q.os8),
        .stop_sel_i   (s_q.stop_sel),
        .bit_ticks_o  (bit_ticks),
        .stop_ticks_o (stop_ticks)
    );

    uart_txf_level #(
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W)
    ) u_level (
        .phase_i (s_q.phase),
        .kind_i  (s_q.kind),
        .slot_i  (s_q.slot),
        .data_i  (s_q.data),
        .level_o (level)
    );

    assign any_req = send_i | idle_req_i | brk_req_i;
    assign accept  = (s_q.phase == PH_IDLE) && any_req;

    always_comb begin
        if (brk_req_i)       req_kind = FR_BREAK;
        else if (idle_req_i) req_kind = FR_FILL;
        else                 req_kind = FR_DATA;
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (any_req) begin
                    s_d.phase    = PH_BODY;
                    s_d.kind     = req_kind;
                    s_d.data     = data_i;
                    s_d.slot     = '0;
                    s_d.tcnt     = '0;
                    s_d.stop_sel = stop_sel_i;
                    s_d.os8      = os8_i;
                end
            end
            PH_BODY: begin
                if (tick_i) begin
                    if (s_q.tcnt == bit_ticks - CNT_W'(1)) begin
                        s_d.tcnt = '0;
                        if (s_q.slot == SLOT_W'(DATA_W)) s_d.phase = PH_STOP;
                        else                             s_d.slot  = s_q.slot + SLOT_W'(1);
                    end else begin
                        s_d.tcnt = s_q.tcnt + CNT_W'(1);
                    end
                end
            end
            default: begin
                if (tick_i) begin
                    if (s_q.tcnt == stop_ticks - CNT_W'(1)) begin
                        s_d.phase = PH_IDLE;
                        s_d.tcnt  = '0;
                        s_d.slot  = '0;
                    end else begin
                        s_d.tcnt = s_q.tcnt + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, kind: FR_DATA, data: '0, slot: '0,
                     tcnt: '0, stop_sel: 2'b00, os8: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_o   = level;
    assign busy_o = (s_q.phase != PH_IDLE);

    // R6
    acc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_o);

    // R1
    quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o);

    // R6
    drop_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tick_i));

    // R7
    frozen_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(s_q.data) && $stable(s_q.stop_sel) && $stable(s_q.os8)));

    // R2
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_BODY) |-> (s_q.tcnt < bit_ticks));

    // R3
    stop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_STOP) |-> (s_q.tcnt < stop_ticks && tx_o));

    // R9
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i) |=> $stable(s_q.tcnt));

endmodule

// File: tb/test_uart_tx_framer.sv
module test_uart_tx_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       send_i = 1'b0;
    logic       idle_req_i = 1'b0;
    logic       brk_req_i = 1'b0;
    logic [1:0] stop_sel_i = 2'b00;
    logic       os8_i = 1'b0;
    logic       tx_o;
    logic       busy_o;

    always #10 clk = ~clk;

    uart_tx_framer #(.DATA_W(8), .OS_HI(16), .OS_LO(8)) i_uart_tx_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .data_i     (data_i),
        .send_i     (send_i),
        .idle_req_i (idle_req_i),
        .brk_req_i  (brk_req_i),
        .stop_sel_i (stop_sel_i),
        .os8_i      (os8_i),
        .tx_o       (tx_o),
        .busy_o     (busy_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    tick_div = 1;
    int    tick_cnt = 0;
    bit    exp_q[$];
    string tag_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // tick source, updated just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (tick_cnt >= tick_div - 1) begin
                tick_i   = 1'b1;
                tick_cnt = 0;
            end else begin
                tick_i   = 1'b0;
                tick_cnt++;
            end
        end
    end

    // monitor: pops one expected level per consumed tick
    initial begin
        bit    prev_busy;
        bit    just_emptied;
        bit    e;
        string t;
        prev_busy    = 1'b0;
        just_emptied = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (just_emptied)
                    check(busy_o == 1'b0, "R6", "busy after last stop tick", busy_o, 0);
                just_emptied = 1'b0;
                if (prev_busy && !busy_o)
                    check(exp_q.size() == 0, "R6", "busy fell with samples left", exp_q.size(), 0);
                if (busy_o && tick_i) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R6", "tick consumed past frame end", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(tx_o == e, t, "tx level", tx_o, e);
                        if (exp_q.size() == 0) just_emptied = 1'b1;
                    end
                end
                prev_busy = busy_o;
            end
        end
    end

    task automatic push_n(input bit lvl, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(lvl);
            tag_q.push_back(tag);
        end
    endtask

    task automatic run_frame(input bit s, input bit idl, input bit brk,
                             input logic [7:0] d, input logic [1:0] sc,
                             input bit o8, input string tag, input bit disturb);
        int tb_t;
        int tb_s;
        @(posedge clk);
        #1;
        while (busy_o) begin
            @(posedge clk);
            #1;
        end
        tb_t = o8 ? 8 : 16;
        case (sc)
            2'b00:   tb_s = tb_t;
            2'b01:   tb_s = tb_t / 2;
            2'b10:   tb_s = tb_t * 2;
            default: tb_s = tb_t + tb_t / 2;
        endcase
        if (brk) begin
            push_n(1'b0, 9 * tb_t, tag);          // R5 / R8
        end else if (idl) begin
            push_n(1'b1, 9 * tb_t, tag);          // R4 / R8
        end else begin
            push_n(1'b0, tb_t, tag);              // R2 start
            for (int b = 0; b < 8; b++) push_n(d[b], tb_t, tag);
        end
        push_n(1'b1, tb_s, {tag, " R3"});
        data_i     = d;
        stop_sel_i = sc;
        os8_i      = o8;
        send_i     = s;
        idle_req_i = idl;
        brk_req_i  = brk;
        @(posedge clk);
        @(negedge clk);
        check(busy_o == 1'b1, "R6", "busy on cycle after accept", busy_o, 1);
        send_i     = 1'b0;
        idle_req_i = 1'b0;
        brk_req_i  = 1'b0;
        if (disturb) begin
            // R7: late request and config changes must not alter the frame
            repeat (5) @(posedge clk);
            #1;
            data_i     = ~d;
            stop_sel_i = ~sc;
            os8_i      = ~o8;
            send_i     = 1'b1;
            idle_req_i = 1'b1;
            brk_req_i  = 1'b1;
            @(posedge clk);
            #1;
            send_i     = 1'b0;
            idle_req_i = 1'b0;
            brk_req_i  = 1'b0;
        end
        @(negedge clk);
        while (busy_o || exp_q.size() != 0) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit quiet_ok;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_o == 1'b1, "R1", "tx after reset", tx_o, 1);
        check(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);

        tick_div = 1;
        run_frame(1, 0, 0, 8'hA5, 2'b00, 0, "R2", 0);
        run_frame(1, 0, 0, 8'h3C, 2'b01, 1, "R2", 0);
        tick_div = 3;
        run_frame(1, 0, 0, 8'h81, 2'b10, 0, "R2 R9", 0);
        tick_div = 2;
        run_frame(1, 0, 0, 8'h6E, 2'b11, 1, "R2 R9", 0);
        tick_div = 1;
        run_frame(0, 1, 0, 8'h00, 2'b11, 0, "R4", 0);
        tick_div = 2;
        run_frame(0, 1, 0, 8'h00, 2'b01, 1, "R4 R9", 0);
        tick_div = 1;
        run_frame(0, 0, 1, 8'hFF, 2'b00, 0, "R5", 0);
        run_frame(0, 0, 1, 8'hFF, 2'b10, 1, "R5", 0);
        run_frame(1, 1, 1, 8'h55, 2'b01, 0, "R8 break wins", 0);
        run_frame(1, 1, 0, 8'h00, 2'b00, 1, "R8 fill wins", 0);
        run_frame(1, 0, 0, 8'h5A, 2'b11, 0, "R7", 1);

        // R7: nothing was queued from the dropped request
        quiet_ok = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (busy_o || !tx_o) quiet_ok = 1'b0;
        end
        check(quiet_ok, "R7", "line quiet after dropped request", quiet_ok, 1);
        check(tx_o == 1'b1, "R1", "tx high while quiet", tx_o, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule